// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers four interrupt sources into one interrupt request line for a CPU. One source is a raster (display line) event and three are DMA sound channels. Each source arrives as a single-cycle request pulse. The block latches each pulse into a pending flag and drives the request line while any flag is pending. When the CPU runs an interrupt acknowledge cycle, the block picks the most urgent pending source in a fixed order. It then places a vector on the data bus that is unique to that source.

Software sets up an 8-bit vector register and reads a status register through a small register bus. The raster flag is always dropped by the acknowledge cycle, and software can also drop it with a write to a mode register. Bit 0 of the vector register selects how DMA flags are cleared. When it is 0, the acknowledge cycle clears the DMA flag it serves. When it is 1, each DMA flag stays pending, and keeps the request line asserted, until software writes a 1 to its status bit. The status register also records whether the last acknowledge served the raster source.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `irq` is 0, the status register (address 1) reads 0x00 and the vector register (address 0) reads 0x01. `irq` is 1 whenever any flag is pending, and a request pulse makes `irq` high from the next cycle.
- R2: The served source is chosen in fixed order: raster first, then DMA channel 2, then channel 1, then channel 0.
- R3: The vector is {vector register bits 7..3, source code, 0}. The source codes are 3 for raster, 2 for DMA2, 1 for DMA1 and 0 for DMA0.
- R4: The start of an acknowledge cycle (the first cycle with `iack` high) clears a pending raster flag in either clear mode.
- R5: A write to address 2 with data bit 4 set clears the raster flag. The same write with bit 4 at 0 leaves the flag as it was.
- R6: With vector register bit 0 at 0, the start of an acknowledge cycle clears the DMA flag it serves and leaves the other DMA flags as they were.
- R7: With vector register bit 0 at 1, an acknowledge cycle clears no DMA flag, and `irq` stays high until software clears the flag.
- R8: Status bits 6, 5 and 4 show the pending flags of DMA channels 0, 1 and 2. Writing 1 to one of these bits clears that flag, writing 0 has no effect, and a write to bit 7 is ignored.
- R9: Status bit 7 is 1 exactly when the most recent acknowledge served the raster source.
- R10: The vector and the flag to clear are latched at the start of the acknowledge cycle. `vec_out` holds that vector from the next cycle until the next acknowledge starts, and a request that arrives during the cycle stays pending.
- R11: When a request pulse and a clear (by software or by acknowledge) hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 vector, 1 status, 2 mode (write only) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| raster_req | input | 1 | Raster interrupt request pulse |
| dma_req | input | 3 | DMA channel request pulses, bit i for channel i |
| iack | input | 1 | CPU interrupt acknowledge cycle, held high for its length |
| irq | output | 1 | Interrupt request to the CPU |
| vec_out | output | 8 | Vector latched by the last acknowledge |

## Verification
Some properties are checked on every clock by assertions. A request pulse always raises the request line and always leaves its flag set, even against a simultaneous clear. Every acknowledge start clears the raster flag and loads the vector with the register's upper bits and a zero low bit. The vector then holds steady while the acknowledge continues, and in manual mode a pending DMA flag keeps the request line up. Other behaviours need the bench's scenarios: the priority order across mixed pending sets, the exact vector value for each source, the status bit layout, and the difference between the auto and manual clear modes. The same holds for requests landing inside an acknowledge and for the mode-register clear with its data bit at 0 and at 1.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int ADDR_VEC  = 0;
   localparam int ADDR_STAT = 1;
   localparam int ADDR_MODE = 2;

   typedef enum logic [1:0] {
      SRC_DMA0   = 2'd0,
      SRC_DMA1   = 2'd1,
      SRC_DMA2   = 2'd2,
      SRC_RASTER = 2'd3
   } irq_src_e;
endpackage

// File: rtl/irqv_flag.sv
module irqv_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   // a fresh request outranks any clear landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_o <= 1'b0;
      else if (set_i)  pend_o <= 1'b1;
      else if (clr_i)  pend_o <= 1'b0;
   end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio import irqv_pkg::*; #(
   parameter int NDMA = 3
) (
   input  logic            raster_i,
   input  logic [NDMA-1:0] dma_i,
   output logic            any_o,
   output logic [1:0]      code_o,
   output logic [NDMA-1:0] sel_o
);
   always_comb begin
      sel_o  = '0;
      code_o = SRC_DMA0;
      // ascending scan: the highest channel index wins
      for (int i = 0; i < NDMA; i++) begin
         if (dma_i[i]) begin
            sel_o    = '0;
            sel_o[i] = 1'b1;
            code_o   = 2'(i);
         end
      end
      if (raster_i) begin
         sel_o  = '0;
         code_o = SRC_RASTER;
      end
      any_o = raster_i | (|dma_i);
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import irqv_pkg::*; #(
   parameter int DW            = 8,
   parameter int NDMA          = 3,
   parameter int ADDR_W        = 2,
   parameter int STAT_LSB      = 4,
   parameter int MODE_RCLR_BIT = 4,
   parameter int IVR_RST_VAL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              raster_req,
   input  logic [NDMA-1:0]   dma_req,
   input  logic              iack,
   output logic              irq,
   output logic [DW-1:0]     vec_out
);
   localparam int CODE_W   = 2;
   localparam int VEC_LO   = CODE_W + 1;
   localparam int LAST_BIT = DW - 1;

   if (DW < VEC_LO + 1) begin : g_bad_dw
      $error("DW too small for vector layout");
   end
   if (NDMA < 1 || NDMA > 3) begin : g_bad_ndma
      $error("NDMA must be 1..3");
   end
   if (STAT_LSB + NDMA > LAST_BIT) begin : g_bad_stat
      $error("status field overlaps last-raster bit");
   end
   if (MODE_RCLR_BIT >= DW) begin : g_bad_mode
      $error("mode clear bit outside data width");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [DW-1:0]     ivr_q, vec_q, stat_byte;
   logic              iack_q, last_ras_q, ack_start;
   logic              raster_pend, any_pend, raster_clr;
   logic [NDMA-1:0]   dma_pend, dma_sel, dma_sw_clr, dma_ack_clr;
   logic [CODE_W-1:0] code;
   logic              wr_vec, wr_stat, wr_mode;

   assign wr_vec    = bus_we && (bus_addr == ADDR_W'(ADDR_VEC));
   assign wr_stat   = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
   assign wr_mode   = bus_we && (bus_addr == ADDR_W'(ADDR_MODE));
   assign ack_start = iack & ~iack_q;

   irqv_prio #(.NDMA(NDMA)) u_prio (
      .raster_i (raster_pend),
      .dma_i    (dma_pend),
      .any_o    (any_pend),
      .code_o   (code),
      .sel_o    (dma_sel)
   );

   assign raster_clr = ack_start | (wr_mode & bus_wdata[MODE_RCLR_BIT]);

   irqv_flag u_ras_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (raster_req),
      .clr_i  (raster_clr),
      .pend_o (raster_pend)
   );

   for (genvar i = 0; i < NDMA; i++) begin : g_dma
      // channel i sits at status bit STAT_LSB+NDMA-1-i
      assign dma_sw_clr[i]  = wr_stat & bus_wdata[STAT_LSB + NDMA - 1 - i];
      assign dma_ack_clr[i] = ack_start & ~ivr_q[0] & dma_sel[i];
      irqv_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (dma_req[i]),
         .clr_i  (dma_sw_clr[i] | dma_ack_clr[i]),
         .pend_o (dma_pend[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ivr_q      <= DW'(IVR_RST_VAL);
         iack_q     <= 1'b0;
         vec_q      <= '0;
         last_ras_q <= 1'b0;
      end else begin
         iack_q <= iack;
         if (wr_vec) ivr_q <= bus_wdata;
         if (ack_start) begin
            vec_q      <= {ivr_q[DW-1:VEC_LO], code, 1'b0};
            last_ras_q <= raster_pend;
         end
      end
   end

   always_comb begin
      stat_byte           = '0;
      stat_byte[LAST_BIT] = last_ras_q;
      for (int i = 0; i < NDMA; i++) stat_byte[STAT_LSB + NDMA - 1 - i] = dma_pend[i];
   end

   always_comb begin
      if (bus_addr == ADDR_W'(ADDR_VEC))       bus_rdata = ivr_q;
      else if (bus_addr == ADDR_W'(ADDR_STAT)) bus_rdata = stat_byte;
      else                                     bus_rdata = '0;
   end

   assign irq     = raster_pend | (|dma_pend);
   assign vec_out = vec_q;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int DW   = 8,
   parameter int NDMA = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            iack,
   input logic            raster_req,
   input logic [NDMA-1:0] dma_req,
   input logic            bus_we,
   input logic            irq,
   input logic [DW-1:0]   vec_out,
   input logic [DW-1:0]   ivr,
   input logic            raster_pend,
   input logic [NDMA-1:0] dma_pend
);
   p_req_raises_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (raster_req || (|dma_req)) |=> irq);

   p_vec_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && !$past(iack)) |=> (vec_out[DW-1:3] == $past(ivr[DW-1:3])) && !vec_out[0]);

   p_raster_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && !$past(iack) && !raster_req) |=> !raster_pend);

   p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ivr[0] && (|dma_pend) && !bus_we) |=> irq);

   p_vec_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && $past(iack)) |=> $stable(vec_out));

   p_dma_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|dma_req) |=> ((dma_pend & $past(dma_req)) == $past(dma_req)));

   p_raster_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      raster_req |=> raster_pend);
endmodule

bind irq_vector_ctrl irqv_checker #(.DW(DW), .NDMA(NDMA)) u_irqv_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .iack        (iack),
   .raster_req  (raster_req),
   .dma_req     (dma_req),
   .bus_we      (bus_we),
   .irq         (irq),
   .vec_out     (vec_out),
   .ivr         (ivr_q),
   .raster_pend (raster_pend),
   .dma_pend    (dma_pend)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       raster_req = 1'b0;
   logic [2:0] dma_req = 3'b000;
   logic       iack = 1'b0;
   logic       irq;
   logic [7:0] vec_out;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raster_req(raster_req),
      .dma_req(dma_req), .iack(iack), .irq(irq), .vec_out(vec_out)
   );

   // behavioural reference model
   int m_ras, m_ivr, m_last, m_vec, m_iprev;
   int m_dma[3];
   int s_start, s_code, s_any, s_clr;
   int s_nd[3];

   function automatic int model_read(int a);
      int v;
      if (a == 0) return m_ivr;
      if (a == 1) begin
         v = m_last ? 8'h80 : 0;
         if (m_dma[0] != 0) v = v | 8'h40;
         if (m_dma[1] != 0) v = v | 8'h20;
         if (m_dma[2] != 0) v = v | 8'h10;
         return v;
      end
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ras = 0; m_ivr = 1; m_last = 0; m_vec = 0; m_iprev = 0;
         for (int i = 0; i < 3; i++) m_dma[i] = 0;
      end else begin
         s_start = (iack && !m_iprev) ? 1 : 0;
         s_any   = (m_ras || m_dma[0] || m_dma[1] || m_dma[2]) ? 1 : 0;
         if (m_ras) s_code = 3;
         else if (m_dma[2]) s_code = 2;
         else if (m_dma[1]) s_code = 1;
         else s_code = 0;
         for (int i = 0; i < 3; i++) begin
            s_clr = 0;
            if (bus_we && bus_addr == 1 && bus_wdata[6-i]) s_clr = 1;
            if (s_start && !(m_ivr & 1) && !m_ras && s_any && s_code == i) s_clr = 1;
            s_nd[i] = dma_req[i] ? 1 : (s_clr ? 0 : m_dma[i]);
         end
         s_clr = (s_start || (bus_we && bus_addr == 2 && bus_wdata[4])) ? 1 : 0;
         if (s_start) begin
            m_vec  = (m_ivr & 8'hF8) | (s_code << 1);
            m_last = m_ras;
         end
         m_ras = raster_req ? 1 : (s_clr ? 0 : m_ras);
         for (int i = 0; i < 3; i++) m_dma[i] = s_nd[i];
         if (bus_we && bus_addr == 0) m_ivr = bus_wdata;
         m_iprev = iack;
      end
   end

   task automatic chk(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R1 irq vs model", int'(irq),
             (m_ras || m_dma[0] || m_dma[1] || m_dma[2]) ? 1 : 0);
         chk("R10 vec_out vs model", int'(vec_out), m_vec);
         chk("R8 rdata vs model", int'(bus_rdata), model_read(int'(bus_addr)));
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic rd(int a, output int v);
      bus_addr = 2'(a);
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic pulse(bit ras, int dma);
      @(negedge clk);
      raster_req = ras; dma_req = 3'(dma);
      @(negedge clk);
      raster_req = 1'b0; dma_req = 3'b000;
   endtask

   task automatic ack(output int v);
      @(negedge clk);
      iack = 1'b1;
      @(negedge clk);
      v = int'(vec_out);
      @(negedge clk);
      iack = 1'b0;
   endtask

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq at reset", int'(irq), 0);
      rd(1, v); chk("R1 status at reset", v, 8'h00);
      rd(0, v); chk("R1 vector reg at reset", v, 8'h01);

      // manual mode: raster + dma2 + dma0
      wr(0, 8'hA9);
      rd(0, v); chk("R3 vector reg write", v, 8'hA9);
      pulse(1'b1, 3'b101);
      chk("R1 irq after request", int'(irq), 1);
      rd(1, v); chk("R8 status layout ch0/ch2", v, 8'h50);
      ack(v); chk("R2 R3 raster first vector", v, 8'hAE);
      rd(1, v); chk("R4 R9 raster cleared, last=raster", v, 8'hD0);
      ack(v); chk("R2 R3 dma2 before dma0 vector", v, 8'hAC);
      rd(1, v); chk("R7 R9 manual keeps dma flags", v, 8'h50);
      chk("R7 irq stays high", int'(irq), 1);
      wr(1, 8'h10); rd(1, v); chk("R8 write1 clears ch2", v, 8'h40);
      wr(1, 8'h00); rd(1, v); chk("R8 write0 no effect", v, 8'h40);
      wr(1, 8'h80); rd(1, v); chk("R8 bit7 write ignored", v, 8'h40);
      wr(1, 8'h40); rd(1, v); chk("R8 write1 clears ch0", v, 8'h00);
      chk("R7 irq drops after clear", int'(irq), 0);

      // auto mode
      wr(0, 8'h30);
      pulse(1'b0, 3'b011);
      rd(1, v); chk("R8 status ch0/ch1", v, 8'h60);
      ack(v); chk("R2 R3 dma1 vector", v, 8'h32);
      rd(1, v); chk("R6 auto clears served only", v, 8'h40);
      ack(v); chk("R3 dma0 vector", v, 8'h30);
      rd(1, v); chk("R6 auto clears dma0", v, 8'h00);
      chk("R6 irq low", int'(irq), 0);

      // mode register clear of raster
      pulse(1'b1, 3'b000);
      wr(2, 8'h00);
      chk("R5 mode write bit4=0 keeps raster", int'(irq), 1);
      wr(2, 8'h10);
      chk("R5 mode write bit4=1 clears raster", int'(irq), 0);

      // request arriving during acknowledge
      pulse(1'b0, 3'b010);
      @(negedge clk); iack = 1'b1;
      @(negedge clk); raster_req = 1'b1; v = int'(vec_out);
      @(negedge clk); raster_req = 1'b0; iack = 1'b0;
      chk("R10 vector latched at start", v, 8'h32);
      chk("R10 vector held after ack", int'(vec_out), 8'h32);
      chk("R10 late raster stays pending", int'(irq), 1);
      rd(1, v); chk("R9 last ack not raster", v, 8'h00);
      wr(2, 8'h10);

      // request and software clear together
      pulse(1'b0, 3'b001);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40; dma_req = 3'b001;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 8'h00; dma_req = 3'b000;
      rd(1, v); chk("R11 set wins over write clear", v, 8'h40);
      // request and auto acknowledge clear together
      @(negedge clk); iack = 1'b1; dma_req = 3'b001;
      @(negedge clk); dma_req = 3'b000;
      @(negedge clk); iack = 1'b0;
      rd(1, v); chk("R11 set wins over ack clear", v, 8'h40);
      chk("R3 R11 vector dma0", int'(vec_out), 8'h30);
      wr(1, 8'h40);
      rd(1, v); chk("R8 final clear", v, 8'h00);

      repeat (2) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         nchk++; nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule